// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a logical address into a physical address for a segmented memory management unit. A request carries a 16-bit selector and a 16-bit offset. The upper 14 selector bits pick an entry in a register-held descriptor table, and the low 2 bits give the privilege the requester asks for. Each entry stores a 24-bit segment base, a 2-bit segment privilege, a present flag and an accessed flag. A valid translation returns base plus offset. A translation that cannot proceed returns a fault code and raises the matching interrupt line. Fault causes are an index beyond the table, a segment that is not resident, or a requester with too little privilege.

Host software fills entries through a one-cycle write port. It reads and clears the accessed flag of any entry through the same index, and uses these flags to pick which segment to evict. Requests use a valid/ready handshake. The response appears, registered, in the cycle after acceptance. A small state machine sequences this. `ST_BOOT` is the reset state and holds ready low. It moves unconditionally to `ST_IDLE`, which accepts requests. An accepted request moves the machine to `ST_RESP`, which presents the response. From `ST_RESP`, another accepted request keeps it in `ST_RESP`, and otherwise it returns to `ST_IDLE`.

Top module: `seg_xlate_top`

## Requirements
- R1: The selector is split into index = sel[15:2] and requested level = sel[1:0]. A request accepted at one clock edge gives rsp_valid high for exactly the following cycle. When no request is accepted, rsp_valid is low in the following cycle.
- R2: A request whose index is in range, whose entry is present and whose privilege check passes returns fault code 00 and rsp_paddr = (base + offset) modulo 2^24.
- R3: An index at or above TBL_DEPTH returns fault code 11 and rsp_paddr 0, with neither interrupt raised. This check takes priority over all other checks.
- R4: An in-range index whose entry is not present returns fault code 01 and rsp_paddr 0, with np_irq high for the response cycle. This check takes priority over the privilege check.
- R5: Access is allowed only when requested level <= segment level (0 is most privileged). Otherwise the response has fault code 10 and rsp_paddr 0, with prot_irq high for the response cycle.
- R6: A fault-free translation sets the entry's accessed flag at its acceptance edge. A faulting translation leaves the flag unchanged.
- R7: A host write (host_wr_en) loads base, level and present flag and clears the accessed flag in one cycle. Requests accepted from the next cycle on see the new contents.
- R8: host_acc_q shows the accessed flag of entry host_idx. host_acc_clr clears that flag at the clock edge.
- R9: When a host write and an accepted translation hit the same entry in one cycle, the translation uses the old contents. The write takes effect, and the accessed flag ends cleared.
- R10: During reset and in the first cycle after it, req_ready is low. After reset every entry is not present with its accessed flag clear, rsp_valid is low, and np_irq and prot_irq are low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 16 | Selector: index in [15:2], requested level in [1:0] |
| req_ofs | input | 16 | Offset within segment |
| rsp_valid | output | 1 | Response valid, one cycle per accepted request |
| rsp_paddr | output | 24 | Physical address, 0 on any fault |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 privilege, 11 out of range |
| np_irq | output | 1 | Not-present interrupt, with response |
| prot_irq | output | 1 | Protection interrupt, with response |
| host_wr_en | input | 1 | Load descriptor host_idx |
| host_idx | input | 4 | Host entry index (write, clear, readback) |
| host_base | input | 24 | Base for descriptor load |
| host_pl | input | 2 | Segment privilege level for descriptor load |
| host_present | input | 1 | Present flag for descriptor load |
| host_acc_clr | input | 1 | Clear accessed flag of host_idx |
| host_acc_q | output | 1 | Accessed flag of host_idx |

## Verification
The bench targets several corner cases:
- An index exactly at the table depth. A design with an off-by-one range check would read a wrapped entry and return an address instead of code 11.
- Equal requested and segment levels. A strict comparison would wrongly refuse these with a protection fault.
- Sums that overflow 24 bits. These expose a missing truncation.
- An entry that is both absent and under-privileged. A wrong check priority would report privilege instead of not-present.
- A host write and a translation landing on the same entry in one cycle. A design that lets the translation win would leave a stale accessed flag set on freshly loaded contents.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_OK    = 2'b00,
        FLT_NP    = 2'b01,
        FLT_PRIV  = 2'b10,
        FLT_RANGE = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'b00,
        ST_IDLE = 2'b01,
        ST_RESP = 2'b10
    } xl_state_e;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
    parameter int DEPTH  = 16,
    parameter int BASE_W = 24,
    parameter int PL_W   = 2,
    localparam int TIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TIDX_W-1:0] host_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [PL_W-1:0]   wr_pl,
    input  logic              wr_present,
    input  logic              clr_en,
    input  logic              set_en,
    input  logic [TIDX_W-1:0] set_idx,
    input  logic [TIDX_W-1:0] lk_idx,
    output logic [BASE_W-1:0] lk_base,
    output logic [PL_W-1:0]   lk_pl,
    output logic              lk_present,
    output logic              host_acc
);

    logic [BASE_W-1:0] base_q [DEPTH];
    logic [PL_W-1:0]   pl_q   [DEPTH];
    logic [DEPTH-1:0]  pres_q;
    logic [DEPTH-1:0]  acc_q;

    // Per-entry storage; host write beats clear, clear beats set.
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic hit_host;
        logic hit_set;
        assign hit_host = (host_idx == TIDX_W'(e));
        assign hit_set  = (set_idx == TIDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[e] <= '0;
                pl_q[e]   <= '0;
                pres_q[e] <= 1'b0;
                acc_q[e]  <= 1'b0;
            end else begin
                if (wr_en && hit_host) begin
                    base_q[e] <= wr_base;
                    pl_q[e]   <= wr_pl;
                    pres_q[e] <= wr_present;
                    acc_q[e]  <= 1'b0;
                end else if (clr_en && hit_host) begin
                    acc_q[e]  <= 1'b0;
                end else if (set_en && hit_set) begin
                    acc_q[e]  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        lk_base    = '0;
        lk_pl      = '0;
        lk_present = 1'b0;
        host_acc   = 1'b0;
        for (int e = 0; e < DEPTH; e++) begin
            if (lk_idx == TIDX_W'(e)) begin
                lk_base    = base_q[e];
                lk_pl      = pl_q[e];
                lk_present = pres_q[e];
            end
            if (host_idx == TIDX_W'(e)) begin
                host_acc = acc_q[e];
            end
        end
    end

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 14,
    parameter int PL_W   = 2,
    parameter int OFS_W  = 16,
    parameter int BASE_W = 24
) (
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [PL_W-1:0]   sel_pl,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BASE_W-1:0] desc_base,
    input  logic [PL_W-1:0]   desc_pl,
    input  logic              desc_present,
    output fault_e            fault,
    output logic [BASE_W-1:0] paddr
);

    logic in_range;
    logic [BASE_W-1:0] sum;

    assign in_range = (32'(sel_idx) < 32'(DEPTH));
    assign sum      = desc_base + BASE_W'(ofs);

    // Priority: range, then presence, then privilege.
    always_comb begin
        fault = FLT_OK;
        paddr = '0;
        if (!in_range) begin
            fault = FLT_RANGE;
        end else if (!desc_present) begin
            fault = FLT_NP;
        end else if (sel_pl > desc_pl) begin
            fault = FLT_PRIV;
        end else begin
            paddr = sum;
        end
    end

endmodule

// File: rtl/seg_xlate_fsm.sv
module seg_xlate_fsm
    import seg_xlate_pkg::*;
#(
    parameter int BASE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  fault_e            chk_fault,
    input  logic [BASE_W-1:0] chk_paddr,
    output logic              req_ready,
    output logic              accept,
    output logic              rsp_valid,
    output fault_e            rsp_fault,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic              np_irq,
    output logic              prot_irq
);

    xl_state_e         state_q;
    xl_state_e         state_d;
    fault_e            fault_q;
    logic [BASE_W-1:0] paddr_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Response payload, captured at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= FLT_OK;
            paddr_q <= '0;
        end else if (accept) begin
            fault_q <= chk_fault;
            paddr_q <= chk_paddr;
        end
    end

    assign accept = req_valid && req_ready;

    // Outputs and next state.
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = FLT_OK;
        rsp_paddr = '0;
        np_irq    = 1'b0;
        prot_irq  = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = ST_RESP;
            end
            ST_RESP: begin
                req_ready = 1'b1;
                rsp_valid = 1'b1;
                rsp_fault = fault_q;
                rsp_paddr = paddr_q;
                np_irq    = (fault_q == FLT_NP);
                prot_irq  = (fault_q == FLT_PRIV);
                state_d   = req_valid ? ST_RESP : ST_IDLE;
            end
            default: begin
                state_d = ST_BOOT;
            end
        endcase
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int TBL_DEPTH = 16,
    parameter int SEL_W     = 16,
    parameter int PL_W      = 2,
    parameter int OFS_W     = 16,
    parameter int BASE_W    = 24,
    localparam int IDX_W  = SEL_W - PL_W,
    localparam int TIDX_W = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [OFS_W-1:0]  req_ofs,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              np_irq,
    output logic              prot_irq,
    input  logic              host_wr_en,
    input  logic [TIDX_W-1:0] host_idx,
    input  logic [BASE_W-1:0] host_base,
    input  logic [PL_W-1:0]   host_pl,
    input  logic              host_present,
    input  logic              host_acc_clr,
    output logic              host_acc_q
);

    logic [IDX_W-1:0]  sel_idx;
    logic [PL_W-1:0]   sel_pl;
    logic [TIDX_W-1:0] lk_idx;
    logic [BASE_W-1:0] lk_base;
    logic [PL_W-1:0]   lk_pl;
    logic              lk_present;
    fault_e            chk_fault;
    logic [BASE_W-1:0] chk_paddr;
    logic              accept;
    fault_e            rsp_fault_e;

    assign sel_idx   = req_sel[SEL_W-1:PL_W];
    assign sel_pl    = req_sel[PL_W-1:0];
    assign lk_idx    = sel_idx[TIDX_W-1:0];
    assign rsp_fault = rsp_fault_e;

    seg_desc_table #(
        .DEPTH (TBL_DEPTH),
        .BASE_W(BASE_W),
        .PL_W  (PL_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .host_idx  (host_idx),
        .wr_base   (host_base),
        .wr_pl     (host_pl),
        .wr_present(host_present),
        .clr_en    (host_acc_clr),
        .set_en    (accept && (chk_fault == FLT_OK)),
        .set_idx   (lk_idx),
        .lk_idx    (lk_idx),
        .lk_base   (lk_base),
        .lk_pl     (lk_pl),
        .lk_present(lk_present),
        .host_acc  (host_acc_q)
    );

    seg_xlate_check #(
        .DEPTH (TBL_DEPTH),
        .IDX_W (IDX_W),
        .PL_W  (PL_W),
        .OFS_W (OFS_W),
        .BASE_W(BASE_W)
    ) check_i (
        .sel_idx     (sel_idx),
        .sel_pl      (sel_pl),
        .ofs         (req_ofs),
        .desc_base   (lk_base),
        .desc_pl     (lk_pl),
        .desc_present(lk_present),
        .fault       (chk_fault),
        .paddr       (chk_paddr)
    );

    seg_xlate_fsm #(
        .BASE_W(BASE_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .chk_fault(chk_fault),
        .chk_paddr(chk_paddr),
        .req_ready(req_ready),
        .accept   (accept),
        .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault_e),
        .rsp_paddr(rsp_paddr),
        .np_irq   (np_irq),
        .prot_irq (prot_irq)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int TBL_DEPTH = 16,
    parameter int SEL_W     = 16,
    parameter int PL_W      = 2,
    parameter int OFS_W     = 16,
    parameter int BASE_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SEL_W-1:0]  req_sel,
    input logic [OFS_W-1:0]  req_ofs,
    input logic              rsp_valid,
    input logic [BASE_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_fault,
    input logic              np_irq,
    input logic              prot_irq,
    input logic [BASE_W-1:0] tbl_base,
    input logic [PL_W-1:0]   tbl_pl,
    input logic              tbl_present
);

    logic acc;
    logic idx_ok;
    assign acc    = req_valid && req_ready;
    assign idx_ok = (32'(req_sel[SEL_W-1:PL_W]) < 32'(TBL_DEPTH));

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid); // R1
    AST_OK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && idx_ok && tbl_present && (req_sel[PL_W-1:0] <= tbl_pl))
        |=> (rsp_fault == 2'b00 && rsp_paddr == $past(tbl_base + BASE_W'(req_ofs)))); // R2
    AST_RANGE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !idx_ok) |=> (rsp_fault == 2'b11 && !np_irq && !prot_irq)); // R3
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0)); // R3
    AST_NP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && idx_ok && !tbl_present) |=> (np_irq && rsp_fault == 2'b01)); // R4
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({np_irq, prot_irq})); // R4
    AST_PRIV_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && idx_ok && tbl_present && (req_sel[PL_W-1:0] > tbl_pl))
        |=> (prot_irq && rsp_fault == 2'b10)); // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!np_irq && !prot_irq)); // R10

endmodule

bind seg_xlate_top seg_xlate_chk #(
    .TBL_DEPTH(TBL_DEPTH),
    .SEL_W    (SEL_W),
    .PL_W     (PL_W),
    .OFS_W    (OFS_W),
    .BASE_W   (BASE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_sel    (req_sel),
    .req_ofs    (req_ofs),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .np_irq     (np_irq),
    .prot_irq   (prot_irq),
    .tbl_base   (lk_base),
    .tbl_pl     (lk_pl),
    .tbl_present(lk_present)
);

// File: tb/seg_xlate_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [15:0] req_ofs = '0;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        np_irq;
    logic        prot_irq;
    logic        host_wr_en = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [23:0] host_base = '0;
    logic [1:0]  host_pl = '0;
    logic        host_present = 1'b0;
    logic        host_acc_clr = 1'b0;
    logic        host_acc_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [23:0] m_base [DEPTH];
    logic [1:0]  m_pl   [DEPTH];
    bit          m_pres [DEPTH];
    bit          m_acc  [DEPTH];

    always #2.5 clk = ~clk;

    seg_xlate_top dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [15:0] sel);
        int idx = int'(sel[15:2]);
        if (idx >= DEPTH) return 2'b11;
        if (!m_pres[idx]) return 2'b01;
        if (sel[1:0] > m_pl[idx]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [23:0] exp_paddr(input logic [15:0] sel, input logic [15:0] ofs);
        if (exp_fault(sel) != 2'b00) return 24'h0;
        return m_base[sel[15:2]] + {8'h00, ofs};
    endfunction

    task automatic host_write(input int idx, input logic [23:0] b, input logic [1:0] pl, input bit p);
        @(negedge clk);
        host_wr_en = 1'b1; host_idx = 4'(idx); host_base = b; host_pl = pl; host_present = p;
        @(negedge clk);
        host_wr_en = 1'b0;
        m_base[idx] = b; m_pl[idx] = pl; m_pres[idx] = p; m_acc[idx] = 0;
    endtask

    task automatic xlate(input logic [15:0] sel, input logic [15:0] ofs, input string req);
        logic [1:0]  ef;
        logic [23:0] ea;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_ofs = ofs;
        ef = exp_fault(sel);
        ea = exp_paddr(sel, ofs);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
        check({req, " irqs"}, {30'd0, np_irq, prot_irq},
              {30'd0, ef == 2'b01, ef == 2'b10});
        if (ef == 2'b00) m_acc[sel[15:2]] = 1;
    endtask

    task automatic acc_read(input int idx, input string req);
        @(negedge clk);
        host_idx = 4'(idx);
        #1;
        check({req, " accessed"}, 32'(host_acc_q), 32'(m_acc[idx]));
    endtask

    task automatic acc_clear(input int idx);
        @(negedge clk);
        host_idx = 4'(idx); host_acc_clr = 1'b1;
        @(negedge clk);
        host_acc_clr = 1'b0;
        m_acc[idx] = 0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0]  of;
        logic [23:0] oa;
        void'($urandom(32'd7315));
        for (int i = 0; i < DEPTH; i++) begin
            m_base[i] = '0; m_pl[i] = '0; m_pres[i] = 0; m_acc[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 ready in reset", 32'(req_ready), 32'd0);
        check("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        check("R10 ready first cycle", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R10 ready after boot", 32'(req_ready), 32'd1);
        acc_read(3, "R10");
        xlate({14'd3, 2'd0}, 16'h0010, "R10 empty entry R4");

        // R2 / R7: load and translate, overflow truncation
        host_write(2, 24'hFFFF00, 2'd3, 1);
        xlate({14'd2, 2'd3}, 16'h0234, "R2 wrap R5 equal level");
        acc_read(2, "R6 set");
        check("R1 rsp drops", 32'(rsp_valid), 32'd0);
        // R5: insufficient privilege
        host_write(4, 24'h123400, 2'd1, 1);
        xlate({14'd4, 2'd2}, 16'h0001, "R5 denied");
        acc_read(4, "R6 fault leaves clear");
        xlate({14'd4, 2'd0}, 16'h00FF, "R5 higher level");
        // R4 priority over privilege
        host_write(5, 24'h00AB00, 2'd0, 0);
        xlate({14'd5, 2'd3}, 16'h0000, "R4 priority");
        // R3 boundary
        xlate({14'(DEPTH), 2'd0}, 16'h0000, "R3 at depth");
        xlate({14'h3FFF, 2'd0}, 16'hFFFF, "R3 max index");
        // R8 clear
        acc_clear(4);
        acc_read(4, "R8 clear");
        // R9: same-entry collision
        host_write(6, 24'h010000, 2'd2, 1);
        @(negedge clk);
        req_valid = 1'b1; req_sel = {14'd6, 2'd1}; req_ofs = 16'h0020;
        host_wr_en = 1'b1; host_idx = 4'd6; host_base = 24'h200000; host_pl = 2'd0; host_present = 1;
        of = exp_fault(req_sel); oa = exp_paddr(req_sel, req_ofs);
        @(negedge clk);
        req_valid = 1'b0; host_wr_en = 1'b0;
        check("R9 old contents fault", 32'(rsp_fault), 32'(of));
        check("R9 old contents paddr", 32'(rsp_paddr), 32'(oa));
        m_base[6] = 24'h200000; m_pl[6] = 2'd0; m_pres[6] = 1; m_acc[6] = 0;
        acc_read(6, "R9 write wins");
        xlate({14'd6, 2'd1}, 16'h0020, "R9 R7 new contents");

        // Constrained random mix
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 5);
            int idx = int'($urandom % (DEPTH + 4));
            if (op == 0) begin
                host_write(idx % DEPTH, 24'($urandom), 2'($urandom), ($urandom % 4) != 0);
            end else if (op == 4) begin
                if ($urandom % 2) acc_clear(idx % DEPTH);
                acc_read(idx % DEPTH, "R8 R6 random");
            end else begin
                xlate({14'(idx), 2'($urandom)}, 16'($urandom), "R1 R2 R3 R4 R5 random");
            end
        end
        for (int i = 0; i < DEPTH; i++) acc_read(i, "R6 final sweep");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule